// File: doc/BRIEF.md
# Display Capability Record Checker

This block examines a 128-byte display capability record while the record streams past, one byte for each cycle in which the valid strobe is high. It needs no buffer for the whole record. A start marker goes with the first byte. Over the record the block keeps a modulo-256 running sum and checks the eight-byte signature at the front. It latches the format version, the format revision and the count of extension blocks that follow.

The record carries four descriptor slots of 18 bytes each. For every slot the block reports whether it holds a timing description or some other kind of descriptor. A slot is a timing description when its pixel-clock word is non-zero. For any other slot the block reports the slot's type code. The first slot that holds a timing description is the preferred mode. The block keeps that slot and rebuilds its split fields: the 12-bit active and blanking counts, the 10-bit horizontal porch and sync widths, the 6-bit vertical porch and sync widths, the pixel clock and the sync flag byte. A start marker that arrives in the middle of a record drops that record and reports it as short.

Top module: `dispcap_parser`

## Requirements
- R1: A byte is accepted when `byte_valid_i` is high. If `start_i` is also high, the byte is byte 0 of a new record. Once byte 127 has been accepted, no record is open, and valid bytes that arrive with no start are ignored. A high `start_i` while `byte_valid_i` is low has no effect.
- R2: `result_valid_o` is high for exactly the one cycle that follows the acceptance of byte 127.
- R3: With the result, `sum_ok_o` is 1 exactly when the sum of all 128 bytes is 0 modulo 256.
- R4: With the result, `hdr_err_o` is 1 exactly when any of bytes 0..7 differs from the pattern 00 FF FF FF FF FF FF 00.
- R5: `version_o` holds byte 18, `revision_o` holds byte 19 and `ext_count_o` holds byte 126 of the record.
- R6: Slot k (k = 0..3) covers bytes 54+18k through 71+18k. In the cycle after the last byte of slot k, `slot_valid_o` pulses with `slot_idx_o` = k. In that pulse, `slot_is_timing_o` is 1 unless slot bytes 0 and 1 are both zero. `slot_type_o` is slot byte 3 for a non-timing slot and 0 for a timing slot.
- R7: `pref_valid_o` goes high with the pulse for the first timing slot of the record and stays high until the next record starts. `pclk_o` = slot byte 0 + 256 × slot byte 1.
- R8: Horizontal active = byte4[7:4]·256 + byte2 and horizontal blanking = byte4[3:0]·256 + byte3. Vertical active and vertical blanking are built the same way from bytes 7, 5 and 6. All four are 12-bit fields.
- R9: Horizontal porch = byte11[7:6]·256 + byte8 and horizontal sync = byte11[5:4]·256 + byte9. Vertical porch = byte11[3:2]·16 + byte10[7:4] and vertical sync = byte11[1:0]·16 + byte10[3:0].
- R10: `sync_flags_o` is byte 17 of the preferred slot.
- R11: When `start_i` and `byte_valid_i` are high while a record is open past byte 0, `short_err_o` pulses for one cycle. The old record then produces no result, and the new record begins with that byte.
- R12: Cycles with `byte_valid_i` low do not advance the record. A record sent with idle gaps gives the same results as one sent without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Marks the accompanying byte as byte 0 |
| byte_valid_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Record byte |
| result_valid_o | output | 1 | One-cycle result strobe |
| sum_ok_o | output | 1 | Record sum is zero |
| hdr_err_o | output | 1 | Signature mismatch |
| short_err_o | output | 1 | Record aborted by an early start |
| version_o | output | 8 | Format version |
| revision_o | output | 8 | Format revision |
| ext_count_o | output | 8 | Extension blocks following |
| slot_valid_o | output | 1 | Slot tag strobe |
| slot_idx_o | output | 2 | Slot number |
| slot_is_timing_o | output | 1 | Slot is a timing description |
| slot_type_o | output | 8 | Type code of a non-timing slot |
| pref_valid_o | output | 1 | Preferred mode captured |
| pclk_o | output | 16 | Pixel clock, 10 kHz units |
| h_active_o | output | 12 | Horizontal active pixels |
| h_blank_o | output | 12 | Horizontal blanking pixels |
| v_active_o | output | 12 | Vertical active lines |
| v_blank_o | output | 12 | Vertical blanking lines |
| h_porch_o | output | 10 | Horizontal front porch |
| h_sync_o | output | 10 | Horizontal sync width |
| v_porch_o | output | 6 | Vertical front porch |
| v_sync_o | output | 6 | Vertical sync width |
| sync_flags_o | output | 8 | Preferred slot flag byte |

## Verification
Two pairs of events can fall in the same cycle. An early start both aborts the open record and supplies byte 0 of the next one. The bench sends 40 bytes and then a full record. It judges this by one short pulse, no result for the partial record, and correct sum, header and slot results for the new one. A result strobe can also coincide with the first byte of a following record. The bench sends records back to back with no idle cycle between them and checks that the held result values are unchanged while the next record is being cleared. The sweep runs over all sixteen patterns of timing and non-timing slots, with and without idle gaps.

// File: rtl/dispcap_pkg.sv
package dispcap_pkg;
  typedef logic [7:0] byte_t;

  function automatic logic [11:0] join_nib(input logic [3:0] hi, input byte_t lo);
    return {hi, lo};
  endfunction

  function automatic logic [9:0] join_two(input logic [1:0] hi, input byte_t lo);
    return {hi, lo};
  endfunction

  function automatic logic [5:0] join_six(input logic [1:0] hi, input logic [3:0] lo);
    return {hi, lo};
  endfunction

  function automatic byte_t sig_byte(input int unsigned idx, input int unsigned len);
    return (idx == 0 || idx == len - 1) ? 8'h00 : 8'hFF;
  endfunction
endpackage

// File: rtl/dispcap_seq.sv
module dispcap_seq #(
  parameter int unsigned REC_BYTES = 128,
  parameter int unsigned IDX_W = $clog2(REC_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             valid_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             accept_o,
  output logic             first_o,
  output logic             last_o,
  output logic             abort_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_BYTES - 1);

  logic [IDX_W-1:0] next_q;
  logic             open_q;

  assign first_o  = valid_i & start_i;
  assign accept_o = valid_i & (start_i | open_q);
  assign abort_o  = first_o & open_q;
  assign idx_o    = start_i ? '0 : next_q;
  assign last_o   = accept_o & (idx_o == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= '0;
      open_q <= 1'b0;
    end else if (accept_o) begin
      next_q <= last_o ? '0 : idx_o + 1'b1;
      open_q <= ~last_o;
    end
  end
endmodule

// File: rtl/dispcap_integrity.sv
module dispcap_integrity
  import dispcap_pkg::*;
#(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned SIG_BYTES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             first_i,
  input  logic [IDX_W-1:0] idx_i,
  input  byte_t            data_i,
  output logic             sum_zero_o,
  output logic             sig_bad_o
);
  byte_t acc_q;
  logic  bad_q;
  byte_t sum_next;
  logic  cur_bad;
  logic  bad_base;

  assign sum_next   = (first_i ? 8'h00 : acc_q) + data_i;
  assign sum_zero_o = (sum_next == 8'h00);
  assign cur_bad    = (int'(idx_i) < int'(SIG_BYTES)) &&
                      (data_i != sig_byte(int'(idx_i), SIG_BYTES));
  assign bad_base   = first_i ? 1'b0 : bad_q;
  assign sig_bad_o  = bad_base | cur_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      bad_q <= 1'b0;
    end else if (accept_i) begin
      acc_q <= sum_next;
      bad_q <= sig_bad_o;
    end
  end
endmodule

// File: rtl/dispcap_slots.sv
module dispcap_slots
  import dispcap_pkg::*;
#(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned SLOT_BASE = 54,
  parameter int unsigned SLOT_LEN = 18,
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned NUM_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             first_i,
  input  logic [IDX_W-1:0] idx_i,
  input  byte_t            data_i,
  output logic             slot_done_o,
  output logic [NUM_W-1:0] slot_num_o,
  output logic             slot_tim_o,
  output byte_t            slot_type_o,
  output logic             found_o,
  output logic [15:0]      pclk_o,
  output logic [11:0]      h_active_o,
  output logic [11:0]      h_blank_o,
  output logic [11:0]      v_active_o,
  output logic [11:0]      v_blank_o,
  output logic [9:0]       h_porch_o,
  output logic [9:0]       h_sync_o,
  output logic [5:0]       v_porch_o,
  output logic [5:0]       v_sync_o,
  output byte_t            flags_o
);
  localparam int unsigned POS_W = $clog2(SLOT_LEN);
  localparam int unsigned SLOT_END = SLOT_BASE + SLOT_LEN * NUM_SLOTS;

  logic             in_rng;
  int unsigned      rel;
  logic [POS_W-1:0] pos;
  logic [NUM_W-1:0] num;
  logic             slot_last;
  byte_t            lo0_q;
  byte_t            typ_q;
  logic             tim_q;
  byte_t            cap_q [SLOT_LEN];

  assign in_rng    = accept_i && (int'(idx_i) >= int'(SLOT_BASE)) && (int'(idx_i) < int'(SLOT_END));
  assign rel       = int'(idx_i) - SLOT_BASE;
  assign pos       = POS_W'(rel % SLOT_LEN);
  assign num       = NUM_W'(rel / SLOT_LEN);
  assign slot_last = in_rng && (int'(pos) == int'(SLOT_LEN) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo0_q       <= '0;
      typ_q       <= '0;
      tim_q       <= 1'b0;
      slot_done_o <= 1'b0;
      slot_num_o  <= '0;
      slot_tim_o  <= 1'b0;
      slot_type_o <= '0;
      found_o     <= 1'b0;
    end else begin
      slot_done_o <= slot_last;
      if (first_i) found_o <= 1'b0;
      if (in_rng && pos == 0) lo0_q <= data_i;
      if (in_rng && pos == 1) tim_q <= (lo0_q != 8'h00) || (data_i != 8'h00);
      if (in_rng && pos == 3) typ_q <= data_i;
      if (slot_last) begin
        slot_num_o  <= num;
        slot_tim_o  <= tim_q;
        slot_type_o <= tim_q ? 8'h00 : typ_q;
        if (tim_q) found_o <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < SLOT_LEN; g++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_q[g] <= '0;
      else if (in_rng && !found_o && int'(pos) == g) cap_q[g] <= data_i;
    end
  end

  assign pclk_o     = {cap_q[1], cap_q[0]};
  assign h_active_o = join_nib(cap_q[4][7:4], cap_q[2]);
  assign h_blank_o  = join_nib(cap_q[4][3:0], cap_q[3]);
  assign v_active_o = join_nib(cap_q[7][7:4], cap_q[5]);
  assign v_blank_o  = join_nib(cap_q[7][3:0], cap_q[6]);
  assign h_porch_o  = join_two(cap_q[11][7:6], cap_q[8]);
  assign h_sync_o   = join_two(cap_q[11][5:4], cap_q[9]);
  assign v_porch_o  = join_six(cap_q[11][3:2], cap_q[10][7:4]);
  assign v_sync_o   = join_six(cap_q[11][1:0], cap_q[10][3:0]);
  assign flags_o    = cap_q[SLOT_LEN-1];
endmodule

// File: rtl/dispcap_parser.sv
module dispcap_parser
  import dispcap_pkg::*;
#(
  parameter int unsigned REC_BYTES = 128,
  parameter int unsigned SIG_BYTES = 8,
  parameter int unsigned VER_POS = 18,
  parameter int unsigned EXT_POS = 126,
  parameter int unsigned SLOT_BASE = 54,
  parameter int unsigned SLOT_LEN = 18,
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  output logic        result_valid_o,
  output logic        sum_ok_o,
  output logic        hdr_err_o,
  output logic        short_err_o,
  output logic [7:0]  version_o,
  output logic [7:0]  revision_o,
  output logic [7:0]  ext_count_o,
  output logic        slot_valid_o,
  output logic [1:0]  slot_idx_o,
  output logic        slot_is_timing_o,
  output logic [7:0]  slot_type_o,
  output logic        pref_valid_o,
  output logic [15:0] pclk_o,
  output logic [11:0] h_active_o,
  output logic [11:0] h_blank_o,
  output logic [11:0] v_active_o,
  output logic [11:0] v_blank_o,
  output logic [9:0]  h_porch_o,
  output logic [9:0]  h_sync_o,
  output logic [5:0]  v_porch_o,
  output logic [5:0]  v_sync_o,
  output logic [7:0]  sync_flags_o
);
  localparam int unsigned IDX_W = $clog2(REC_BYTES);

  logic [IDX_W-1:0] evt_idx;
  logic             evt_accept;
  logic             evt_first;
  logic             evt_last;
  logic             evt_abort;
  logic             sum_zero;
  logic             sig_bad;

  dispcap_seq #(.REC_BYTES(REC_BYTES), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(byte_valid_i),
    .idx_o(evt_idx), .accept_o(evt_accept), .first_o(evt_first),
    .last_o(evt_last), .abort_o(evt_abort)
  );

  dispcap_integrity #(.IDX_W(IDX_W), .SIG_BYTES(SIG_BYTES)) u_integ (
    .clk(clk), .rst_n(rst_n), .accept_i(evt_accept), .first_i(evt_first),
    .idx_i(evt_idx), .data_i(byte_i), .sum_zero_o(sum_zero), .sig_bad_o(sig_bad)
  );

  dispcap_slots #(
    .IDX_W(IDX_W), .SLOT_BASE(SLOT_BASE), .SLOT_LEN(SLOT_LEN),
    .NUM_SLOTS(NUM_SLOTS), .NUM_W(2)
  ) u_slots (
    .clk(clk), .rst_n(rst_n), .accept_i(evt_accept), .first_i(evt_first),
    .idx_i(evt_idx), .data_i(byte_i),
    .slot_done_o(slot_valid_o), .slot_num_o(slot_idx_o), .slot_tim_o(slot_is_timing_o),
    .slot_type_o(slot_type_o), .found_o(pref_valid_o), .pclk_o(pclk_o),
    .h_active_o(h_active_o), .h_blank_o(h_blank_o), .v_active_o(v_active_o),
    .v_blank_o(v_blank_o), .h_porch_o(h_porch_o), .h_sync_o(h_sync_o),
    .v_porch_o(v_porch_o), .v_sync_o(v_sync_o), .flags_o(sync_flags_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_valid_o <= 1'b0;
      sum_ok_o       <= 1'b0;
      hdr_err_o      <= 1'b0;
      short_err_o    <= 1'b0;
      version_o      <= '0;
      revision_o     <= '0;
      ext_count_o    <= '0;
    end else begin
      result_valid_o <= evt_last;
      short_err_o    <= evt_abort;
      if (evt_last) begin
        sum_ok_o  <= sum_zero;
        hdr_err_o <= sig_bad;
      end
      if (evt_accept && int'(evt_idx) == int'(VER_POS))     version_o   <= byte_i;
      if (evt_accept && int'(evt_idx) == int'(VER_POS) + 1) revision_o  <= byte_i;
      if (evt_accept && int'(evt_idx) == int'(EXT_POS))     ext_count_o <= byte_i;
    end
  end
endmodule

// File: rtl/dispcap_parser_sva.sv
module dispcap_parser_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        byte_valid_i,
  input logic        result_valid_o,
  input logic        short_err_o,
  input logic        slot_valid_o,
  input logic        slot_is_timing_o,
  input logic        pref_valid_o,
  input logic [15:0] pclk_o,
  input logic        evt_abort
);
  // R2
  result_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |=> !result_valid_o);
  // R2
  result_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> $past(byte_valid_i));
  // R11
  short_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_err_o |-> $past(start_i && byte_valid_i));
  // R11
  short_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_abort |=> !result_valid_o);
  // R6
  slot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid_o |=> !slot_valid_o);
  // R7
  pref_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pref_valid_o) |-> (slot_valid_o && slot_is_timing_o));
  // R7
  pref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pref_valid_o && !(start_i && byte_valid_i)) |=> (pref_valid_o && $stable(pclk_o)));
endmodule

bind dispcap_parser dispcap_parser_sva u_sva (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
  .result_valid_o(result_valid_o), .short_err_o(short_err_o),
  .slot_valid_o(slot_valid_o), .slot_is_timing_o(slot_is_timing_o),
  .pref_valid_o(pref_valid_o), .pclk_o(pclk_o), .evt_abort(evt_abort)
);

// File: tb/dispcap_parser_bench.sv
module dispcap_parser_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic byte_valid_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic result_valid_o, sum_ok_o, hdr_err_o, short_err_o;
  logic [7:0] version_o, revision_o, ext_count_o, slot_type_o, sync_flags_o;
  logic slot_valid_o, slot_is_timing_o, pref_valid_o;
  logic [1:0] slot_idx_o;
  logic [15:0] pclk_o;
  logic [11:0] h_active_o, h_blank_o, v_active_o, v_blank_o;
  logic [9:0] h_porch_o, h_sync_o;
  logic [5:0] v_porch_o, v_sync_o;

  always #2 clk = ~clk;

  dispcap_parser u_dispcap_parser (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
    .result_valid_o(result_valid_o), .sum_ok_o(sum_ok_o), .hdr_err_o(hdr_err_o),
    .short_err_o(short_err_o), .version_o(version_o), .revision_o(revision_o),
    .ext_count_o(ext_count_o), .slot_valid_o(slot_valid_o), .slot_idx_o(slot_idx_o),
    .slot_is_timing_o(slot_is_timing_o), .slot_type_o(slot_type_o),
    .pref_valid_o(pref_valid_o), .pclk_o(pclk_o), .h_active_o(h_active_o),
    .h_blank_o(h_blank_o), .v_active_o(v_active_o), .v_blank_o(v_blank_o),
    .h_porch_o(h_porch_o), .h_sync_o(h_sync_o), .v_porch_o(v_porch_o),
    .v_sync_o(v_sync_o), .sync_flags_o(sync_flags_o)
  );

  int checks = 0, fails = 0;
  int res_seen = 0, short_seen = 0, slot_cnt = 0;
  bit done = 0;
  int rec [128];
  int exp_tim [4], exp_typ [4];
  int b_sum, b_hdr, b_pv, b_ver, b_rev, b_ext, b_pclk, b_ha, b_hb, b_va, b_vb, b_hp, b_hs, b_vp, b_vs, b_fl;
  int r_sum, r_hdr, r_pv, r_ver, r_rev, r_ext, r_pclk, r_ha, r_hb, r_va, r_vb, r_hp, r_hs, r_vp, r_vs, r_fl;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build(input int seed, input int mask, input bit bad_sum, input int hdr_idx);
    int s, first, base;
    for (int i = 0; i < 128; i++) rec[i] = (i * 37 + seed * 11 + 5) % 256;
    for (int i = 0; i < 8; i++) rec[i] = (i == 0 || i == 7) ? 0 : 255;
    if (hdr_idx >= 0) rec[hdr_idx] = rec[hdr_idx] ^ 16;
    rec[18] = 1; rec[19] = seed % 8; rec[126] = seed % 3;
    first = -1;
    for (int k = 0; k < 4; k++) begin
      base = 54 + 18 * k;
      if (mask[k]) begin
        rec[base] = ((seed * 3 + k) * 2 + 1) % 256;
        exp_tim[k] = 1; exp_typ[k] = 0;
        if (first < 0) first = k;
      end else begin
        rec[base] = 0; rec[base + 1] = 0; rec[base + 2] = 0;
        rec[base + 3] = 252 + (k + seed) % 4;
        exp_tim[k] = 0; exp_typ[k] = rec[base + 3];
      end
    end
    s = 0;
    for (int i = 0; i < 127; i++) s += rec[i];
    rec[127] = (256 - s % 256) % 256;
    if (bad_sum) rec[127] = (rec[127] + 1) % 256;
    b_sum = !bad_sum; b_hdr = (hdr_idx >= 0);
    b_ver = rec[18]; b_rev = rec[19]; b_ext = rec[126];
    b_pv = (first >= 0);
    if (first >= 0) begin
      base = 54 + 18 * first;
      b_pclk = rec[base] + 256 * rec[base + 1];
      b_ha = (rec[base + 4] / 16) * 256 + rec[base + 2];
      b_hb = (rec[base + 4] % 16) * 256 + rec[base + 3];
      b_va = (rec[base + 7] / 16) * 256 + rec[base + 5];
      b_vb = (rec[base + 7] % 16) * 256 + rec[base + 6];
      b_hp = ((rec[base + 11] / 64) % 4) * 256 + rec[base + 8];
      b_hs = ((rec[base + 11] / 16) % 4) * 256 + rec[base + 9];
      b_vp = ((rec[base + 11] / 4) % 4) * 16 + rec[base + 10] / 16;
      b_vs = (rec[base + 11] % 4) * 16 + rec[base + 10] % 16;
      b_fl = rec[base + 17];
    end
  endtask

  // Drives n bytes of rec; in gap mode idle cycles hold start high with valid low (R1, R12).
  task automatic send(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) slot_cnt = 0;
      start_i = (i == 0); byte_valid_i = 1'b1; byte_i = 8'(rec[i]);
      if (gaps && (i % 7 == 3)) begin
        @(negedge clk);
        start_i = 1'b1; byte_valid_i = 1'b0; byte_i = 8'hA5;
      end
    end
    if (n == 128) begin
      r_sum = b_sum; r_hdr = b_hdr; r_pv = b_pv; r_ver = b_ver; r_rev = b_rev; r_ext = b_ext;
      r_pclk = b_pclk; r_ha = b_ha; r_hb = b_hb; r_va = b_va; r_vb = b_vb;
      r_hp = b_hp; r_hs = b_hs; r_vp = b_vp; r_vs = b_vs; r_fl = b_fl;
    end
  endtask

  task automatic idle_check(input int exp_res);
    @(negedge clk);
    start_i = 1'b0; byte_valid_i = 1'b0;
    chk("R2 result strobe after last byte", int'(result_valid_o), 1);
    @(negedge clk);
    chk("R2 result strobe single cycle", int'(result_valid_o), 0);
    chk("R1 result count", res_seen, exp_res);
  endtask

  always @(negedge clk) begin
    if (rst_n && slot_valid_o) begin
      chk("R6 slot index", int'(slot_idx_o), slot_cnt);
      chk("R6 slot timing tag", int'(slot_is_timing_o), exp_tim[slot_cnt % 4]);
      chk("R6 slot type", int'(slot_type_o), exp_typ[slot_cnt % 4]);
      slot_cnt++;
    end
    if (rst_n && short_err_o) short_seen++;
    if (rst_n && result_valid_o) begin
      res_seen++;
      chk("R3 sum ok", int'(sum_ok_o), r_sum);
      chk("R4 header error", int'(hdr_err_o), r_hdr);
      chk("R5 version", int'(version_o), r_ver);
      chk("R5 revision", int'(revision_o), r_rev);
      chk("R5 extension count", int'(ext_count_o), r_ext);
      chk("R7 preferred valid", int'(pref_valid_o), r_pv);
      if (r_pv != 0) begin
        chk("R7 pixel clock", int'(pclk_o), r_pclk);
        chk("R8 h active", int'(h_active_o), r_ha);
        chk("R8 h blank", int'(h_blank_o), r_hb);
        chk("R8 v active", int'(v_active_o), r_va);
        chk("R8 v blank", int'(v_blank_o), r_vb);
        chk("R9 h porch", int'(h_porch_o), r_hp);
        chk("R9 h sync", int'(h_sync_o), r_hs);
        chk("R9 v porch", int'(v_porch_o), r_vp);
        chk("R9 v sync", int'(v_sync_o), r_vs);
        chk("R10 sync flags", int'(sync_flags_o), r_fl);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int exp_res;
    exp_res = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset result", int'(result_valid_o), 0);
    chk("R7 reset pref", int'(pref_valid_o), 0);
    chk("R11 reset short", int'(short_err_o), 0);
    chk("R6 reset slot", int'(slot_valid_o), 0);

    // Sweep every timing/non-timing slot pattern, with and without gaps (R6, R7, R12)
    for (int m = 0; m < 16; m++) begin
      build(m, m, 1'b0, -1);
      send(128, m[0]);
      exp_res++;
      idle_check(exp_res);
      chk("R6 four slots tagged", slot_cnt, 4);
    end

    // Bad checksum (R3) and signature corruption at both ends and middle (R4)
    build(30, 9, 1'b1, -1); send(128, 1'b0); exp_res++; idle_check(exp_res);
    build(31, 2, 1'b0, 0);  send(128, 1'b0); exp_res++; idle_check(exp_res);
    build(32, 4, 1'b0, 7);  send(128, 1'b0); exp_res++; idle_check(exp_res);
    build(33, 8, 1'b0, 4);  send(128, 1'b1); exp_res++; idle_check(exp_res);

    // Stray bytes with no open record are ignored (R1)
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      start_i = 1'b0; byte_valid_i = 1'b1; byte_i = 8'h37;
    end
    @(negedge clk);
    byte_valid_i = 1'b0;
    build(40, 3, 1'b0, -1); send(128, 1'b0); exp_res++; idle_check(exp_res);
    chk("R1 stray bytes cause no short", short_seen, 0);

    // Short block: early start aborts, then a new full record (R11)
    build(20, 5, 1'b1, -1); send(40, 1'b0);
    build(21, 6, 1'b0, -1); send(128, 1'b0); exp_res++; idle_check(exp_res);
    chk("R11 short pulse count", short_seen, 1);

    // Back-to-back records: result of one coincides with byte 0 of next (R2, R11)
    build(50, 12, 1'b0, -1); send(128, 1'b0); exp_res++;
    build(51, 1, 1'b0, 3);   send(128, 1'b0); exp_res++;
    idle_check(exp_res);
    chk("R11 back-to-back gives no short", short_seen, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule